// File: doc/BRIEF.md
# Paired-Mode DAC Code Register Bank

This block sits between an 8-bit I/O bus and sixteen 12-bit converter channels. Each channel receives its code as two byte writes. The low byte is written first into a holding register. The write of the high nibble forms the complete 12-bit word. A second register rank drives the code lines, so a channel never presents a code that is only half written.

Channels are grouped in pairs, and each pair has a static mode input. In individual mode, the high-nibble write moves the new code to the output at once. In simultaneous mode, the complete code is parked in a pending register. Every parked channel then moves to its output together, on the first read of any address inside the block's 32-byte window. Reads return zero and exist only to fire that group transfer.

The block matches a 32-byte aligned window on the 10-bit address. It can optionally insert one wait cycle on each access that hits the window.

The ready path is a two-state machine. WS_IDLE keeps ready high. The transition "stall on hit" goes from WS_IDLE to WS_STALL when a strobe hits the window while waits are enabled. WS_STALL holds ready low, and the transition "release" returns it to WS_IDLE on the next cycle.

Each channel has a three-state machine:
- CH_IDLE: nothing is outstanding.
- CH_LOW_HELD: a low byte is waiting for its high nibble.
- CH_ARMED: a complete code is parked in simultaneous mode.

Its transitions are:
- "low load": any state goes to CH_LOW_HELD on a low-byte write.
- "direct commit": CH_LOW_HELD goes to CH_IDLE on a high write in individual mode.
- "park": CH_IDLE or CH_LOW_HELD goes to CH_ARMED on a high write in simultaneous mode.
- "group commit": CH_ARMED goes to CH_IDLE on a window read in simultaneous mode.

A window read in CH_LOW_HELD leaves the channel in CH_LOW_HELD.

Top module: `dac_regbank_top`

## Requirements
- R1: After reset, every channel code is 0x000, bus_ready is 1 and bus_rdata is 0x00.
- R2: Channel n's low byte is at window offset 2n and its high nibble is at offset 2n+1. The code is {high[3:0], low[7:0]}, and bits 7..4 of the high write are ignored.
- R3: In individual mode, a high-nibble write makes the new code visible on the channel's output in the cycle after the write. A low-byte write alone leaves the output unchanged.
- R4: Bit p of pair_sync selects simultaneous mode for both channels 2p and 2p+1.
- R5: In simultaneous mode, a high-nibble write leaves the channel's output unchanged.
- R6: A read of any address in the window moves the last complete code of every simultaneous-mode channel to its output, all in the same cycle. Individual-mode channels are unaffected.
- R7: If a low byte has been written without its high nibble when a window read arrives, the channel commits its previous complete code and keeps the partial low byte for the next high write.
- R8: The window is active when bus_addr[9:5] equals base_sel. Writes and reads outside it change no output and trigger no transfer.
- R9: With wait_en = 1, bus_ready is low for exactly the one cycle after a strobe that hits the window. It stays high for misses, and always when wait_en = 0.
- R10: bus_rdata is always 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 5 | Window base, address bits 9..5 |
| wait_en | input | 1 | Enable the one-cycle wait on window hits |
| pair_sync | input | 8 | Per-pair mode, 1 = simultaneous |
| bus_addr | input | 10 | Byte address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, always zero |
| bus_ready | output | 1 | Low during an inserted wait cycle |
| dac_code | output | 192 | Channel n code at bits [12n+11:12n] |

## Verification
Every result of this block is due one clock edge after its strobe: the individual-mode output after the high write, the group transfer after the read, and the ready low pulse after the hit. Ready then returns high one edge later. The bench drives each strobe on a falling edge and holds it across exactly one rising edge. It samples every output at the following falling edge, so each check lands in the first cycle the result is due. The wait check also covers the cycle after that. For the "unchanged" cases, the bench samples all sixteen codes at that same falling edge, before the next stimulus.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_LOW_HELD = 2'd1,
        CH_ARMED    = 2'd2
    } chan_state_e;

    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_STALL = 1'b1
    } wait_state_e;

endpackage

// File: rtl/dac_addr_dec.sv
module dac_addr_dec #(
    parameter int ADDR_W = 10,
    parameter int NUM_CH = 16
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ADDR_W-WIN_W-1:0]  base_sel,
    input  logic                     wr,
    input  logic                     rd,
    output logic                     hit_strobe,
    output logic                     xfer,
    output logic [NUM_CH-1:0]        lo_we,
    output logic [NUM_CH-1:0]        hi_we
);
    localparam int WIN_W = $clog2(NUM_CH * 2);
    localparam int CH_W  = WIN_W - 1;

    logic            in_win;
    logic [CH_W-1:0] ch_idx;
    logic            is_hi;

    always_comb begin
        in_win     = (addr[ADDR_W-1:WIN_W] == base_sel);
        ch_idx     = addr[WIN_W-1:1];
        is_hi      = addr[0];
        hit_strobe = in_win && (wr || rd);
        xfer       = in_win && rd;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_we
        always_comb begin
            lo_we[g] = in_win && wr && !is_hi && (ch_idx == CH_W'(g));
            hi_we[g] = in_win && wr &&  is_hi && (ch_idx == CH_W'(g));
        end
    end

    always_comb begin
        AST_ONE_TARGET: assert ($onehot0({lo_we, hi_we})); // R2
    end

endmodule

// File: rtl/dac_wait_fsm.sv
module dac_wait_fsm
    import dac_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_strobe,
    input  logic wait_en,
    output logic ready
);
    wait_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (hit_strobe && wait_en) state_d = WS_STALL;
            WS_STALL: state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready = (state_q == WS_IDLE);
    end

    AST_READY_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready); // R9
    AST_STALL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(hit_strobe && wait_en)) |=> ready); // R9
    AST_STALL_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && hit_strobe && wait_en) |=> !ready); // R9

endmodule

// File: rtl/dac_chan.sv
module dac_chan
    import dac_regbank_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              xfer,
    input  logic              sync_mode,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CODE_W-1:0] code_o
);
    localparam int HI_W = CODE_W - BYTE_W;

    chan_state_e       state_q, state_d;
    logic [BYTE_W-1:0] lo_q;
    logic [CODE_W-1:0] pend_q;
    logic [CODE_W-1:0] out_q;
    logic [CODE_W-1:0] joined;
    logic              group_go;

    always_comb begin
        joined   = {wdata[HI_W-1:0], lo_q};
        group_go = xfer && sync_mode;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (lo_we)                  state_d = CH_LOW_HELD;
                else if (hi_we && sync_mode) state_d = CH_ARMED;
            end
            CH_LOW_HELD: begin
                if (hi_we) state_d = sync_mode ? CH_ARMED : CH_IDLE;
            end
            CH_ARMED: begin
                if (lo_we)         state_d = CH_LOW_HELD;
                else if (group_go) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            pend_q <= '0;
            out_q  <= '0;
        end else begin
            if (lo_we) lo_q <= wdata;
            if (hi_we) begin
                pend_q <= joined;
                if (!sync_mode) out_q <= joined;
            end else if (group_go) begin
                out_q <= pend_q;
            end
        end
    end

    always_comb begin
        code_o = out_q;
    end

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_we && !xfer) |=> $stable(code_o)); // R3
    AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && sync_mode) |=> $stable(code_o)); // R5
    AST_PARTIAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_LOW_HELD && group_go && !hi_we && !lo_we) |=> (state_q == CH_LOW_HELD)); // R7
    AST_INDIV_IGNORES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !sync_mode && !hi_we) |=> $stable(code_o)); // R6

endmodule

// File: rtl/dac_regbank_top.sv
module dac_regbank_top #(
    parameter int NUM_CH = 16,
    parameter int CODE_W = 12,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10,
    localparam int WIN_W  = $clog2(NUM_CH * 2),
    localparam int BASE_W = ADDR_W - WIN_W,
    localparam int PAIRS  = NUM_CH / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BASE_W-1:0]        base_sel,
    input  logic                     wait_en,
    input  logic [PAIRS-1:0]         pair_sync,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    output logic                     bus_ready,
    output logic [NUM_CH*CODE_W-1:0] dac_code
);
    logic              hit_strobe;
    logic              xfer;
    logic [NUM_CH-1:0] lo_we;
    logic [NUM_CH-1:0] hi_we;

    dac_addr_dec #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) u_dec (
        .addr       (bus_addr),
        .base_sel   (base_sel),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .hit_strobe (hit_strobe),
        .xfer       (xfer),
        .lo_we      (lo_we),
        .hi_we      (hi_we)
    );

    dac_wait_fsm u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_strobe (hit_strobe),
        .wait_en    (wait_en),
        .ready      (bus_ready)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dac_chan #(
            .CODE_W (CODE_W),
            .BYTE_W (BYTE_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .lo_we     (lo_we[g]),
            .hi_we     (hi_we[g]),
            .xfer      (xfer),
            .sync_mode (pair_sync[g/2]),
            .wdata     (bus_wdata),
            .code_o    (dac_code[g*CODE_W +: CODE_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
    end

    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && (bus_addr[ADDR_W-1:WIN_W] != base_sel)) |=> $stable(dac_code)); // R8

endmodule

// File: tb/dac_regbank_top_tb.sv
module dac_regbank_top_tb;
    localparam int NCH = 16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  base_sel = 5'd24;
    logic        wait_en = 0;
    logic [7:0]  pair_sync = 8'h00;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic        bus_rd = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_ready;
    logic [NCH*12-1:0] dac_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [11:0] m_out  [NCH];
    logic [11:0] m_pend [NCH];
    logic [7:0]  m_lo   [NCH];

    always #2 clk = ~clk;

    dac_regbank_top u_dut (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .wait_en(wait_en),
        .pair_sync(pair_sync), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .dac_code(dac_code)
    );

    function automatic logic [11:0] code_of(int ch);
        return dac_code[ch*12 +: 12];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < NCH; c++)
            check(code_of(c) == m_out[c], req, code_of(c), m_out[c]);
    endtask

    function automatic bit hits(logic [9:0] a);
        return a[9:5] == base_sel;
    endfunction

    // one strobe cycle; model follows R2..R8, ready follows R9
    task automatic bus_op(bit is_rd, logic [9:0] a, logic [7:0] d, string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = !is_rd; bus_rd = is_rd;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        if (hits(a)) begin
            if (is_rd) begin
                for (int c = 0; c < NCH; c++)
                    if (pair_sync[c/2]) m_out[c] = m_pend[c];
            end else begin
                int ch = a[4:1];
                if (!a[0]) m_lo[ch] = d;
                else begin
                    m_pend[ch] = {d[3:0], m_lo[ch]};
                    if (!pair_sync[ch/2]) m_out[ch] = m_pend[ch];
                end
            end
        end
        check(bus_ready == !(hits(a) && wait_en), "R9", bus_ready, !(hits(a) && wait_en));
        check(bus_rdata == 8'h00, "R10", bus_rdata, 0);
        check_all(req);
    endtask

    function automatic logic [9:0] adr(int ch, bit hi);
        return {base_sel, 4'(ch), hi};
    endfunction

    task automatic t_reset;
        for (int c = 0; c < NCH; c++) begin m_out[c] = 0; m_pend[c] = 0; m_lo[c] = 0; end
        check(bus_ready == 1, "R1", bus_ready, 1);
        check(bus_rdata == 0, "R1", bus_rdata, 0);
        check_all("R1");
    endtask

    task automatic t_individual;
        bus_op(0, adr(3, 0), 8'hAB, "R3");
        check(code_of(3) == 12'h000, "R3", code_of(3), 0);
        bus_op(0, adr(3, 1), 8'hF5, "R2");
        check(code_of(3) == 12'h5AB, "R2", code_of(3), 12'h5AB);
        bus_op(0, adr(15, 0), 8'h01, "R2");
        bus_op(0, adr(15, 1), 8'h0C, "R2");
        check(code_of(15) == 12'hC01, "R2", code_of(15), 12'hC01);
    endtask

    task automatic t_sync;
        pair_sync = 8'h04;
        bus_op(0, adr(4, 0), 8'h23, "R5");
        bus_op(0, adr(4, 1), 8'h01, "R5");
        bus_op(0, adr(5, 0), 8'h56, "R5");
        bus_op(0, adr(5, 1), 8'h04, "R4");
        check(code_of(4) == 0 && code_of(5) == 0, "R5", code_of(5), 0);
        bus_op(0, adr(0, 0), 8'h77, "R3");
        bus_op(0, adr(0, 1), 8'h07, "R3");
        check(code_of(0) == 12'h777, "R3", code_of(0), 12'h777);
        bus_op(1, {base_sel, 5'd31}, 8'h00, "R6");
        check(code_of(4) == 12'h123, "R6", code_of(4), 12'h123);
        check(code_of(5) == 12'h456, "R6", code_of(5), 12'h456);
        check(code_of(3) == 12'h5AB, "R6", code_of(3), 12'h5AB);
    endtask

    task automatic t_partial;
        bus_op(0, adr(5, 0), 8'h00, "R7");
        bus_op(0, adr(5, 1), 8'h08, "R7");
        bus_op(0, adr(5, 0), 8'h11, "R7");
        bus_op(1, adr(9, 0), 8'h00, "R7");
        check(code_of(5) == 12'h800, "R7", code_of(5), 12'h800);
        bus_op(0, adr(5, 1), 8'h00, "R7");
        bus_op(1, adr(0, 0), 8'h00, "R7");
        check(code_of(5) == 12'h011, "R7", code_of(5), 12'h011);
    endtask

    task automatic t_window;
        bus_op(0, 10'h200, 8'hEE, "R8");
        bus_op(0, 10'h201, 8'h0E, "R8");
        check(code_of(0) == 12'h777, "R8", code_of(0), 12'h777);
        bus_op(0, adr(4, 0), 8'h99, "R8");
        bus_op(0, adr(4, 1), 8'h09, "R8");
        bus_op(1, 10'h31F ^ 10'h020, 8'h00, "R8");
        check(code_of(4) == 12'h123, "R8", code_of(4), 12'h123);
        base_sel = 5'd16;
        bus_op(1, 10'h205, 8'h00, "R8");
        check(code_of(4) == 12'h999, "R8", code_of(4), 12'h999);
        base_sel = 5'd24;
    endtask

    task automatic t_wait;
        wait_en = 1;
        bus_op(0, adr(7, 0), 8'h42, "R9");
        @(negedge clk);
        check(bus_ready == 1, "R9", bus_ready, 1);
        bus_op(1, 10'h000, 8'h00, "R9");
        bus_op(1, adr(2, 1), 8'h00, "R9");
        wait_en = 0;
        bus_op(0, adr(7, 1), 8'h03, "R9");
        check(code_of(7) == 12'h342, "R3", code_of(7), 12'h342);
    endtask

    task automatic t_all_sync;
        pair_sync = 8'h01;
        bus_op(0, adr(1, 0), 8'h10, "R4");
        bus_op(0, adr(1, 1), 8'h02, "R4");
        check(code_of(1) == 12'h000, "R4", code_of(1), 0);
        pair_sync = 8'hFF;
        for (int c = 0; c < NCH; c++) begin
            bus_op(0, adr(c, 0), 8'(c * 17), "R5");
            bus_op(0, adr(c, 1), 8'(c), "R5");
        end
        bus_op(1, adr(11, 1), 8'h00, "R6");
        for (int c = 0; c < NCH; c++)
            check(code_of(c) == {4'(c), 8'(c * 17)}, "R6", code_of(c), {4'(c), 8'(c * 17)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_individual();
        t_sync();
        t_partial();
        t_window();
        t_wait();
        t_all_sync();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule